// File: doc/BRIEF.md
# Phase compensation bit FIFO

This block moves a single-bit stream of recovered receive data from the clock of the sampling phase that was picked for the channel into the shared high-speed receive clock. The two clocks run at the same rate and differ only in phase. Each channel can sample on a different phase, so a small elastic store re-times the bits. The store holds six one-bit entries. The write side fills one entry on every cycle of its clock, and the read side drains one entry on every cycle of the receive clock. The write pointer crosses into the read domain as a 3-bit Johnson code, so only one bit changes per step.

The store stays empty from power-up until the phase controller first reports lock. On that first lock it clears itself and starts. The read side waits until the synchronised write pointer is three entries ahead of its own pointer, so it has equal margin towards running dry and towards being overrun. After a loss of lock, when the receiving logic finds the data corrupt, a user clear input restarts the store the same way. The block does no rate matching. If the clocks drift apart in frequency, the synchronised gap eventually wraps to zero and a sticky error flag rises.

Top module: `phase_comp_bitfifo`

## Requirements
- R1: The store has 6 one-bit entries. While both clocks run at the same frequency, every bit taken on `din` after a start comes out on `dout` exactly once and in the order it was written. Bits written during a clear are not taken.
- R2: From the release of `rst_n` until `lock_in` is first seen high, `dout`, `dout_ok` and `err` stay 0 whatever `din` carries.
- R3: The first rising edge of `lock_in` after reset clears and starts the store. `dout_ok` goes high within 40 `rd_clk` cycles and stays high as long as no clear occurs.
- R4: Once the first lock has been seen, dropping `lock_in` and raising it again causes no clear. `dout_ok` stays high and the stream carries on with no bit lost.
- R5: A rising edge of `user_clr` clears the store. Within 8 `rd_clk` cycles `dout_ok`, `dout` and `err` are 0, and the store restarts by itself within a further 40 cycles.
- R6: `dout` is 0 whenever `dout_ok` is 0. Reading starts once the synchronised write pointer leads the read pointer by 3 entries, and from then on `dout_ok` is 1.
- R7: `err` rises when the synchronised gap between the pointers reaches 0 modulo 6. This happens when the write clock runs faster than the read clock and also when it runs slower.
- R8: Once raised, `err` stays high until the next clear.
- R9: With equal clock frequencies and a constant phase offset, `err` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Clock of the selected sampling phase (write side) |
| rd_clk | input | 1 | Common high-speed receive clock (read side) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| lock_in | input | 1 | Lock indication from the phase controller; its first rise starts the store |
| user_clr | input | 1 | User clear request; its rising edge clears and restarts the store |
| din | input | 1 | Recovered data bit, sampled on `wr_clk` |
| dout | output | 1 | Re-timed data bit on `rd_clk`; 0 when no data is valid |
| dout_ok | output | 1 | High while `dout` carries data from the store |
| err | output | 1 | Sticky flag: the synchronised gap reached 0 or 6 |

## Verification
A wrong pointer, a wrong wrap point or a wrong read start shows up at the ports as a stream that is shifted, repeated or missing bits. The comparison catches this on the first bit after the start marker, which is a few cycles after `dout_ok` rises. A clear or lock-edge decoder that is wrong shows up as `dout_ok` staying low, or dropping in the middle of a stream, within the 8 to 40 cycle windows that the requirements give. A wrong gap comparison shows up as `err` rising under equal clocks, or staying low after a frequency excursion. The check runs a few cycles after that excursion ends.

// File: rtl/pcf_pkg.sv
`timescale 1ns/1ps
package pcf_pkg;
  // read side sequencing: waiting for the start gap, or draining every cycle
  typedef enum logic {
    RS_FILL = 1'b0,
    RS_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/pcf_rst_sync.sv
`timescale 1ns/1ps
// asynchronous assert, synchronous release of an active-low reset
module pcf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pcf_sync.sv
`timescale 1ns/1ps
// multi-stage level synchroniser with a chosen reset value
module pcf_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcf_wr_side.sv
`timescale 1ns/1ps
// write domain: storage entries, binary write address and Johnson pointer
module pcf_wr_side #(
  parameter int unsigned JW     = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              clr_async,
  input  logic              din,
  output logic [JW-1:0]     wptr_j,
  output logic [2*JW-1:0]   store
);
  localparam int unsigned DEPTH = 2 * JW;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic          clr_s;
  logic [AW-1:0] wadr_q, wadr_d;
  logic [JW-1:0] wj_q, wj_d;

  // clear request from the read domain; held as "clear" while in reset
  pcf_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_clr_sync (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (clr_async),
    .q     (clr_s)
  );

  always_comb begin
    if (clr_s) begin
      wadr_d = '0;
      wj_d   = '0;
    end else begin
      wadr_d = (wadr_q == AW'(DEPTH - 1)) ? '0 : wadr_q + 1'b1;
      wj_d   = {wj_q[JW-2:0], ~wj_q[JW-1]};
    end
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wadr_q <= '0;
      wj_q   <= '0;
    end else begin
      wadr_q <= wadr_d;
      wj_q   <= wj_d;
    end
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic ent_q;
      logic ent_en;
      assign ent_en = !clr_s && (wadr_q == AW'(e));
      always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n)   ent_q <= 1'b0;
        else if (ent_en) ent_q <= din;
      end
      assign store[e] = ent_q;
    end
  endgenerate

  assign wptr_j = wj_q;
endmodule

// File: rtl/pcf_rd_side.sv
`timescale 1ns/1ps
// read domain: clear control, pointer gap, read sequencing and error flag
module pcf_rd_side
  import pcf_pkg::*;
#(
  parameter int unsigned JW      = 3,
  parameter int unsigned STAGES  = 2,
  parameter int unsigned GAP     = 3,
  parameter int unsigned CLR_CYC = 8
) (
  input  logic            rd_clk,
  input  logic            rd_rst_n,
  input  logic            lock_async,
  input  logic            uclr_async,
  input  logic [JW-1:0]   wptr_async,
  input  logic [2*JW-1:0] store,
  output logic            dout,
  output logic            dout_ok,
  output logic            err,
  output logic            clr_req
);
  localparam int unsigned DEPTH = 2 * JW;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(CLR_CYC + 1);

  logic          lock_s, uclr_s;
  logic          lock_q, uclr_q;
  logic          seen_q, seen_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clr_q, clr_d;
  logic [JW-1:0] wsync_j;
  logic [AW-1:0] wbin, gap, rptr_q, rptr_d;
  rd_state_e     st_q, st_d;
  logic          dout_q, dout_d, ok_q, ok_d, err_q, err_d;
  logic          rd_en;
  logic          start_ev;

  pcf_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk (rd_clk), .rst_n (rd_rst_n), .d (lock_async), .q (lock_s)
  );
  pcf_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_uclr_sync (
    .clk (rd_clk), .rst_n (rd_rst_n), .d (uclr_async), .q (uclr_s)
  );
  pcf_sync #(.WIDTH(JW), .STAGES(STAGES), .RST_VAL('0)) u_wptr_sync (
    .clk (rd_clk), .rst_n (rd_rst_n), .d (wptr_async), .q (wsync_j)
  );

  // Johnson code to entry index: leading zero means count of ones,
  // leading one means DEPTH minus count of ones
  function automatic logic [AW-1:0] j2b(input logic [JW-1:0] j);
    int unsigned ones;
    ones = $countones(j);
    if (j[JW-1]) return AW'(DEPTH - ones);
    else         return AW'(ones);
  endfunction

  always_comb begin
    wbin = j2b(wsync_j);
    gap  = (wbin >= rptr_q) ? (wbin - rptr_q) : (wbin + AW'(DEPTH) - rptr_q);
  end

  // clear control: first lock edge or user clear edge reloads the window
  always_comb begin
    start_ev = (lock_s && !lock_q && !seen_q) || (uclr_s && !uclr_q);
    seen_d   = seen_q | lock_s;
    if (start_ev)              cnt_d = CW'(CLR_CYC);
    else if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    else                       cnt_d = cnt_q;
    clr_d = !seen_d || (cnt_d != '0);
  end

  // read sequencing
  always_comb begin
    st_d   = st_q;
    rptr_d = rptr_q;
    dout_d = dout_q;
    ok_d   = ok_q;
    err_d  = err_q;
    rd_en  = 1'b0;
    if (clr_q) begin
      st_d   = RS_FILL;
      rptr_d = '0;
      dout_d = 1'b0;
      ok_d   = 1'b0;
      err_d  = 1'b0;
    end else begin
      rd_en = (st_q == RS_RUN) || (gap == AW'(GAP));
      if (rd_en) begin
        dout_d = store[rptr_q];
        rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
        ok_d   = 1'b1;
        st_d   = RS_RUN;
      end
      if ((st_q == RS_RUN) && (gap == '0)) err_d = 1'b1;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      lock_q <= 1'b0;
      uclr_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      clr_q  <= 1'b1;
      st_q   <= RS_FILL;
      rptr_q <= '0;
      dout_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      lock_q <= lock_s;
      uclr_q <= uclr_s;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      clr_q  <= clr_d;
      st_q   <= st_d;
      rptr_q <= rptr_d;
      dout_q <= dout_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
    end
  end

  assign dout    = dout_q;
  assign dout_ok = ok_q;
  assign err     = err_q;
  assign clr_req = clr_q;
endmodule

// File: rtl/phase_comp_bitfifo.sv
`timescale 1ns/1ps
module phase_comp_bitfifo #(
  parameter int unsigned JW          = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned START_GAP   = 3,
  parameter int unsigned CLR_CYC     = 8
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic lock_in,
  input  logic user_clr,
  input  logic din,
  output logic dout,
  output logic dout_ok,
  output logic err
);
  logic            wr_rst_n, rd_rst_n;
  logic            clr_req;
  logic [JW-1:0]   wptr_j;
  logic [2*JW-1:0] store;

  pcf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk (wr_clk), .arst_n (rst_n), .srst_n (wr_rst_n)
  );
  pcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk (rd_clk), .arst_n (rst_n), .srst_n (rd_rst_n)
  );

  pcf_wr_side #(.JW(JW), .STAGES(SYNC_STAGES)) u_wr (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .clr_async (clr_req),
    .din       (din),
    .wptr_j    (wptr_j),
    .store     (store)
  );

  pcf_rd_side #(
    .JW (JW), .STAGES (SYNC_STAGES), .GAP (START_GAP), .CLR_CYC (CLR_CYC)
  ) u_rd (
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .lock_async (lock_in),
    .uclr_async (user_clr),
    .wptr_async (wptr_j),
    .store      (store),
    .dout       (dout),
    .dout_ok    (dout_ok),
    .err        (err),
    .clr_req    (clr_req)
  );
endmodule

// File: rtl/phase_comp_bitfifo_chk.sv
`timescale 1ns/1ps
module phase_comp_bitfifo_chk (
  input logic rd_clk,
  input logic rst_n,
  input logic dout,
  input logic dout_ok,
  input logic err,
  input logic clr_req
);
  // R6: no data bit while nothing valid is presented
  a_r6_idle_zero: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !dout_ok |-> !dout);

  // R5: a pending clear empties the outputs on the next cycle
  a_r5_clear_empties: assert property (@(posedge rd_clk) disable iff (!rst_n)
    clr_req |=> (!dout_ok && !err));

  // R8: error flag holds until a clear arrives
  a_r8_err_sticky: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (err && !clr_req) |=> err);

  // R7: an error can only exist while the read side is running
  a_r7_err_in_run: assert property (@(posedge rd_clk) disable iff (!rst_n)
    err |-> dout_ok);

  // R3: once started, valid output persists without a clear
  a_r3_run_holds: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (dout_ok && !clr_req) |=> dout_ok);
endmodule

bind phase_comp_bitfifo phase_comp_bitfifo_chk u_chk (
  .rd_clk  (rd_clk),
  .rst_n   (rst_n),
  .dout    (dout),
  .dout_ok (dout_ok),
  .err     (err),
  .clr_req (clr_req)
);

// File: tb/phase_comp_bitfifo_tb.sv
`timescale 1ns/1ps
module phase_comp_bitfifo_tb;
  logic wr_clk, rd_clk, rst_n, lock_in, user_clr, din;
  logic dout, dout_ok, err;

  int checks = 0;
  int failures = 0;
  real wr_half = 10.0;

  bit sbq[$];
  bit sb_en = 0;
  bit stream_on = 0;
  bit first_pending = 0;
  bit found = 0;
  int pushed = 0;
  int popped = 0;
  logic [15:0] lfsr = 16'hACE1;

  phase_comp_bitfifo u_dut (
    .wr_clk (wr_clk), .rd_clk (rd_clk), .rst_n (rst_n), .lock_in (lock_in),
    .user_clr (user_clr), .din (din), .dout (dout), .dout_ok (dout_ok), .err (err)
  );

  // 50 MHz clocks, read clock lags the write clock by 7 ns
  initial begin
    wr_clk = 1'b0;
    forever #(wr_half) wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 1'b0;
    #7;
    forever #10 rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // driver: fill bits are 1; a stream starts with a 0 marker then LFSR data
  initial begin
    din = 1'b1;
    forever begin
      @(negedge wr_clk);
      if (stream_on) begin
        bit b;
        if (first_pending) begin
          b = 1'b0;
          first_pending = 0;
        end else begin
          b = lfsr[0];
          lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        din = b;
        sbq.push_back(b);
        pushed++;
      end else begin
        din = 1'b1;
      end
    end
  end

  // monitor: idle-zero rule and scoreboard comparison
  initial begin
    forever begin
      @(negedge rd_clk);
      if (!dout_ok) chk(dout == 1'b0, "R6", "dout while not valid", dout, 0);
      if (sb_en && dout_ok && sbq.size() > 0) begin
        if (!found) begin
          if (dout == 1'b0) begin
            bit m;
            m = sbq.pop_front();
            popped++;
            found = 1;
            chk(m == 1'b0, "R1", "start marker", dout, m);
          end
        end else begin
          bit e;
          e = sbq.pop_front();
          popped++;
          chk(dout == e, "R1", "stream bit", dout, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge rd_clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic wait_ok(input string req, input int limit);
    int n;
    n = 0;
    while (!dout_ok && n < limit) begin
      @(negedge rd_clk);
      n++;
    end
    chk(dout_ok == 1'b1, req, "start within limit", dout_ok, 1);
  endtask

  task automatic run_stream(input int nbits, input string req);
    pushed = 0;
    popped = 0;
    found = 0;
    sbq.delete();
    sb_en = 1;
    @(negedge wr_clk);
    first_pending = 1;
    stream_on = 1;
    repeat (nbits) @(negedge wr_clk);
    stream_on = 0;
    repeat (20) @(negedge rd_clk);
    chk(popped == pushed && sbq.size() == 0, req, "all bits delivered", popped, pushed);
    sb_en = 0;
  endtask

  task automatic pulse_user_clr();
    @(negedge rd_clk);
    user_clr = 1'b1;
    repeat (4) @(negedge rd_clk);
    user_clr = 1'b0;
    repeat (4) @(negedge rd_clk);
    chk(dout_ok == 1'b0, "R5", "dout_ok after clear", dout_ok, 0);
    chk(dout == 1'b0, "R5", "dout after clear", dout, 0);
    chk(err == 1'b0, "R5", "err after clear", err, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    lock_in = 1'b0;
    user_clr = 1'b0;
    repeat (5) @(negedge rd_clk);
    chk(dout == 1'b0 && dout_ok == 1'b0 && err == 1'b0, "R2", "reset state",
        {29'd0, dout, dout_ok, err}, 0);
    rst_n = 1'b1;

    // R2: held empty before the first lock while din is 1
    for (int i = 0; i < 5; i++) begin
      repeat (10) @(negedge rd_clk);
      chk(dout_ok == 1'b0 && dout == 1'b0 && err == 1'b0, "R2", "no output before lock",
          {29'd0, dout, dout_ok, err}, 0);
    end

    // R3: first lock starts the store
    lock_in = 1'b1;
    wait_ok("R3", 40);
    chk(dout == 1'b1, "R6", "first read is a fill bit", dout, 1);

    // R1 + R4 + R9: stream with a lock drop and re-rise in the middle
    pushed = 0; popped = 0; found = 0; sbq.delete();
    sb_en = 1;
    @(negedge wr_clk);
    first_pending = 1;
    stream_on = 1;
    repeat (80) @(negedge rd_clk);
    lock_in = 1'b0;
    repeat (10) @(negedge rd_clk);
    lock_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      repeat (10) @(negedge rd_clk);
      chk(dout_ok == 1'b1, "R4", "no clear on later lock edge", dout_ok, 1);
    end
    repeat (80) @(negedge wr_clk);
    stream_on = 0;
    repeat (20) @(negedge rd_clk);
    chk(popped == pushed && sbq.size() == 0, "R4", "stream intact across lock edge", popped, pushed);
    chk(popped > 150, "R1", "bits compared", popped, 151);
    sb_en = 0;
    chk(err == 1'b0, "R9", "no error at equal rates", err, 0);

    // R5: user clear and restart, then a fresh stream
    pulse_user_clr();
    wait_ok("R5", 40);
    run_stream(100, "R1");
    chk(err == 1'b0, "R9", "no error after restart", err, 0);

    // R7: write clock faster for 40 cycles
    @(posedge wr_clk);
    wr_half = 8.5;
    repeat (40) @(posedge wr_clk);
    wr_half = 10.0;
    repeat (6) @(negedge rd_clk);
    chk(err == 1'b1, "R7", "error on fast write clock", err, 1);
    repeat (20) @(negedge rd_clk);
    chk(err == 1'b1, "R8", "error stays set", err, 1);

    pulse_user_clr();
    wait_ok("R5", 40);
    repeat (30) @(negedge rd_clk);
    chk(err == 1'b0, "R9", "clean after recovery", err, 0);

    // R7: write clock slower for 40 cycles
    @(posedge wr_clk);
    wr_half = 11.5;
    repeat (40) @(posedge wr_clk);
    wr_half = 10.0;
    repeat (6) @(negedge rd_clk);
    chk(err == 1'b1, "R7", "error on slow write clock", err, 1);

    pulse_user_clr();
    wait_ok("R5", 40);
    run_stream(100, "R1");
    chk(err == 1'b0, "R9", "no error on final stream", err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule